// File: doc/BRIEF.md
# Sequence-Protected Flash Rewrite Control Register

This block holds the control bits that put an embedded flash into its rewrite mode. It has two registers on a simple CPU register bus: an address, a write strobe, write data and combinational read data. Most bits in the two registers are ordinary read/write bits. Three bits are guarded. Any single write can clear a guarded bit. Setting a guarded bit to 1 needs two writes in a row: the first writes 0 to that bit and the second writes 1 to it. No other write and no interrupt-handler or DMA cycle may come between them, and the non-maskable interrupt (NMI) pin must be high when the write of 1 happens. The rewrite-mode bit also requires that bus wait states are enabled and that the slow CPU clock is selected.

A pulse on the NMI event input or on the watchdog event input returns both registers to their reset contents at once. If rewrite mode was active at that moment, the block raises a one-cycle abort pulse so the program/erase sequencer stops. Software must then restart the rewrite.

Top module: `flash_rw_ctrl`

## Requirements
- R1: A synchronous active-low reset sets register A to 0x80 and register B to 0x20. Every guarded bit resets to 0, the abort output resets to 0, and all unlock state is dropped.
- R2: Register A is at address 0 and register B is at address 1. A single write replaces every unguarded bit of the addressed register. Writes to addresses 2 and 3 change nothing.
- R3: A write of 0 to a guarded bit clears it on that clock edge. No sequence is needed.
- R4: The guarded bits are A bit 0 (rewrite mode), A bit 1 and B bit 0. A write of 1 sets a guarded bit only if the write just before it went to the same register, wrote 0 to that bit, and was not tagged as an alternate master. Otherwise the bit keeps its value.
- R5: Any cycle with the alternate-master tag high (interrupt handler or DMA) between the two writes breaks the sequence. A tagged write can clear guarded bits but can never set them or start a sequence.
- R6: A write of 1 to a guarded bit is ignored when the NMI pin is low during that write.
- R7: The rewrite-mode bit (A bit 0) also needs the wait-state enable and the slow-clock select inputs to be 1 during its write of 1. If either is 0, the write of 1 is ignored.
- R8: An NMI event or a watchdog event returns both registers to their R1 values on the next edge. It overrides a write in the same cycle and drops any pending sequence.
- R9: The abort output is high for exactly the one cycle after the edge that took an event, and only if the rewrite-mode bit was 1 before that edge.
- R10: Read data gives the addressed register (0 for unmapped addresses) with no side effects. A read between the two writes of a sequence does not break it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| addr_i | input | 2 | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| alt_master_i | input | 1 | Current bus cycle belongs to an interrupt handler or DMA |
| nmi_pin_i | input | 1 | NMI pin level |
| nmi_evt_i | input | 1 | NMI event pulse |
| wdt_evt_i | input | 1 | Watchdog event pulse |
| wait_en_i | input | 1 | Bus wait states enabled |
| clk_slow_i | input | 1 | CPU clock is at or below the rewrite limit |
| ctrl_a_o | output | 8 | Register A contents |
| ctrl_b_o | output | 8 | Register B contents |
| abort_o | output | 1 | One-cycle rewrite abort pulse |

## Verification
The hardest situation to reach is a write of 1 that meets some of the unlock conditions but not all of them. Examples are a broken sequence, a low NMI pin, or a missing clock or wait-state qualifier. In each case the bit must stay exactly as it was. The bench sweeps every guarded bit against every combination of pin, wait-state and clock inputs and against five kinds of gap between the two writes: none, a read, a write to the other register, a tagged idle cycle and a tagged write. After each step it compares both registers and the read data with a model built from the requirements. Events are then injected while the guarded bits are set, while a sequence is half done, and together with a write, to exercise the abort pulse and the override order.

// File: rtl/flash_rw_pkg.sv
package flash_rw_pkg;

    // How one bus cycle relates to a given register
    typedef enum logic [1:0] {
        ACC_NONE    = 2'd0,  // nothing happened
        ACC_OWN     = 2'd1,  // plain CPU write to this register
        ACC_OWN_ALT = 2'd2,  // tagged (interrupt/DMA) write to this register
        ACC_DISARM  = 2'd3   // some other write or a tagged cycle
    } acc_kind_e;

    typedef struct packed {
        logic armed;
        logic val;
    } prot_bit_t;

    typedef struct packed {
        logic abort;
    } evt_state_t;

endpackage

// File: rtl/fr_bus_dec.sv
module fr_bus_dec
    import flash_rw_pkg::*;
#(
    parameter int AW     = 2,
    parameter int ADDR_A = 0,
    parameter int ADDR_B = 1
) (
    input  logic [AW-1:0] addr_i,
    input  logic          we_i,
    input  logic          alt_i,
    output acc_kind_e     kind_a_o,
    output acc_kind_e     kind_b_o,
    output logic          wr_a_o,
    output logic          wr_b_o
);

    localparam logic [AW-1:0] SEL_A = AW'(ADDR_A);
    localparam logic [AW-1:0] SEL_B = AW'(ADDR_B);

    logic hit_a, hit_b, any_cyc;

    always_comb begin
        hit_a   = we_i && (addr_i == SEL_A);
        hit_b   = we_i && (addr_i == SEL_B);
        any_cyc = we_i || alt_i;

        if (hit_a)        kind_a_o = alt_i ? ACC_OWN_ALT : ACC_OWN;
        else if (any_cyc) kind_a_o = ACC_DISARM;
        else              kind_a_o = ACC_NONE;

        if (hit_b)        kind_b_o = alt_i ? ACC_OWN_ALT : ACC_OWN;
        else if (any_cyc) kind_b_o = ACC_DISARM;
        else              kind_b_o = ACC_NONE;

        wr_a_o = hit_a;
        wr_b_o = hit_b;
    end

endmodule

// File: rtl/fr_prot_bit.sv
module fr_prot_bit
    import flash_rw_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      clear_i,
    input  acc_kind_e kind_i,
    input  logic      wbit_i,
    input  logic      set_ok_i,
    output logic      val_o
);

    prot_bit_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else begin
            case (kind_i)
                ACC_OWN: begin
                    if (!wbit_i) begin
                        st_d.val   = 1'b0;
                        st_d.armed = 1'b1;
                    end else begin
                        if (st_q.armed && set_ok_i) st_d.val = 1'b1;
                        st_d.armed = 1'b0;
                    end
                end
                ACC_OWN_ALT: begin
                    if (!wbit_i) st_d.val = 1'b0;
                    st_d.armed = 1'b0;
                end
                ACC_DISARM: st_d.armed = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign val_o = st_q.val;

endmodule

// File: rtl/fr_event_ctl.sv
module fr_event_ctl
    import flash_rw_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic nmi_evt_i,
    input  logic wdt_evt_i,
    input  logic mode_i,
    output logic clear_o,
    output logic abort_o
);

    evt_state_t ev_d, ev_q;

    always_comb begin
        clear_o     = nmi_evt_i || wdt_evt_i;
        ev_d        = ev_q;
        ev_d.abort  = clear_o && mode_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) ev_q <= '0;
        else         ev_q <= ev_d;
    end

    assign abort_o = ev_q.abort;

endmodule

// File: rtl/flash_rw_ctrl.sv
module flash_rw_ctrl
    import flash_rw_pkg::*;
#(
    parameter int            DW       = 8,
    parameter int            AW       = 2,
    parameter int            ADDR_A   = 0,
    parameter int            ADDR_B   = 1,
    parameter logic [DW-1:0] PROT_A   = 8'h03,
    parameter logic [DW-1:0] PROT_B   = 8'h01,
    parameter int            MODE_BIT = 0,
    parameter logic [DW-1:0] RST_A    = 8'h80,
    parameter logic [DW-1:0] RST_B    = 8'h20
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [AW-1:0] addr_i,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    input  logic          alt_master_i,
    input  logic          nmi_pin_i,
    input  logic          nmi_evt_i,
    input  logic          wdt_evt_i,
    input  logic          wait_en_i,
    input  logic          clk_slow_i,
    output logic [DW-1:0] ctrl_a_o,
    output logic [DW-1:0] ctrl_b_o,
    output logic          abort_o
);

    localparam logic [DW-1:0] OPEN_A  = ~PROT_A;
    localparam logic [DW-1:0] OPEN_B  = ~PROT_B;
    localparam logic [DW-1:0] RST_PA  = RST_A & OPEN_A;
    localparam logic [DW-1:0] RST_PB  = RST_B & OPEN_B;
    localparam logic [AW-1:0] SEL_A   = AW'(ADDR_A);
    localparam logic [AW-1:0] SEL_B   = AW'(ADDR_B);

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
    } plain_t;

    acc_kind_e     kind_a, kind_b;
    logic          wr_a, wr_b;
    logic          ev_clear;
    logic          speed_ok;
    logic [DW-1:0] prot_a, prot_b;
    plain_t        pl_d, pl_q;

    fr_bus_dec #(
        .AW     (AW),
        .ADDR_A (ADDR_A),
        .ADDR_B (ADDR_B)
    ) u_dec (
        .addr_i   (addr_i),
        .we_i     (we_i),
        .alt_i    (alt_master_i),
        .kind_a_o (kind_a),
        .kind_b_o (kind_b),
        .wr_a_o   (wr_a),
        .wr_b_o   (wr_b)
    );

    fr_event_ctl u_evt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .nmi_evt_i (nmi_evt_i),
        .wdt_evt_i (wdt_evt_i),
        .mode_i    (prot_a[MODE_BIT]),
        .clear_o   (ev_clear),
        .abort_o   (abort_o)
    );

    assign speed_ok = wait_en_i && clk_slow_i;

    // Guarded bits of register A
    for (genvar i = 0; i < DW; i++) begin : g_a
        if (PROT_A[i]) begin : g_prot
            fr_prot_bit u_bit (
                .clk_i    (clk_i),
                .rst_ni   (rst_ni),
                .clear_i  (ev_clear),
                .kind_i   (kind_a),
                .wbit_i   (wdata_i[i]),
                .set_ok_i (nmi_pin_i && ((i != MODE_BIT) || speed_ok)),
                .val_o    (prot_a[i])
            );
        end else begin : g_open
            assign prot_a[i] = 1'b0;
        end
    end

    // Guarded bits of register B
    for (genvar i = 0; i < DW; i++) begin : g_b
        if (PROT_B[i]) begin : g_prot
            fr_prot_bit u_bit (
                .clk_i    (clk_i),
                .rst_ni   (rst_ni),
                .clear_i  (ev_clear),
                .kind_i   (kind_b),
                .wbit_i   (wdata_i[i]),
                .set_ok_i (nmi_pin_i),
                .val_o    (prot_b[i])
            );
        end else begin : g_open
            assign prot_b[i] = 1'b0;
        end
    end

    // Unguarded bits
    always_comb begin
        pl_d = pl_q;
        if (ev_clear) begin
            pl_d.a = RST_PA;
            pl_d.b = RST_PB;
        end else begin
            if (wr_a) pl_d.a = wdata_i & OPEN_A;
            if (wr_b) pl_d.b = wdata_i & OPEN_B;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pl_q.a <= RST_PA;
            pl_q.b <= RST_PB;
        end else begin
            pl_q <= pl_d;
        end
    end

    assign ctrl_a_o = pl_q.a | prot_a;
    assign ctrl_b_o = pl_q.b | prot_b;

    always_comb begin
        if (addr_i == SEL_A)      rdata_o = ctrl_a_o;
        else if (addr_i == SEL_B) rdata_o = ctrl_b_o;
        else                      rdata_o = '0;
    end

endmodule

// File: rtl/flash_rw_ctrl_chk.sv
module flash_rw_ctrl_chk #(
    parameter int            DW       = 8,
    parameter int            MODE_BIT = 0,
    parameter logic [DW-1:0] RST_A    = 8'h80,
    parameter logic [DW-1:0] RST_B    = 8'h20
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          we_i,
    input logic [DW-1:0] wdata_i,
    input logic          alt_master_i,
    input logic          nmi_pin_i,
    input logic          nmi_evt_i,
    input logic          wdt_evt_i,
    input logic          wait_en_i,
    input logic          clk_slow_i,
    input logic [DW-1:0] ctrl_a_o,
    input logic [DW-1:0] ctrl_b_o,
    input logic          abort_o
);

    assert_evt_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nmi_evt_i || wdt_evt_i) |=> (ctrl_a_o == RST_A && ctrl_b_o == RST_B));

    assert_abort_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_o |-> ($past(nmi_evt_i || wdt_evt_i) && $past(ctrl_a_o[MODE_BIT])));

    assert_abort_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_o |=> !abort_o);

    assert_mode_pin_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ctrl_a_o[MODE_BIT]) |-> $past(nmi_pin_i));

    assert_mode_speed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ctrl_a_o[MODE_BIT]) |-> $past(wait_en_i && clk_slow_i));

    assert_mode_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ctrl_a_o[MODE_BIT]) |-> ($past(we_i) && $past(wdata_i[MODE_BIT]) && !$past(alt_master_i)));

    assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!we_i && !nmi_evt_i && !wdt_evt_i) |=> ($stable(ctrl_a_o) && $stable(ctrl_b_o)));

endmodule

bind flash_rw_ctrl flash_rw_ctrl_chk #(
    .DW       (DW),
    .MODE_BIT (MODE_BIT),
    .RST_A    (RST_A),
    .RST_B    (RST_B)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (we_i),
    .wdata_i      (wdata_i),
    .alt_master_i (alt_master_i),
    .nmi_pin_i    (nmi_pin_i),
    .nmi_evt_i    (nmi_evt_i),
    .wdt_evt_i    (wdt_evt_i),
    .wait_en_i    (wait_en_i),
    .clk_slow_i   (clk_slow_i),
    .ctrl_a_o     (ctrl_a_o),
    .ctrl_b_o     (ctrl_b_o),
    .abort_o      (abort_o)
);

// File: tb/flash_rw_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_rw_ctrl_tb_top;

    localparam logic [7:0] PA = 8'h03;
    localparam logic [7:0] PB = 8'h01;
    localparam logic [7:0] RA = 8'h80;
    localparam logic [7:0] RB = 8'h20;

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic [1:0] addr_i = '0;
    logic       we_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic       alt_master_i = 1'b0;
    logic       nmi_pin_i = 1'b1;
    logic       nmi_evt_i = 1'b0;
    logic       wdt_evt_i = 1'b0;
    logic       wait_en_i = 1'b1;
    logic       clk_slow_i = 1'b1;
    logic [7:0] ctrl_a_o, ctrl_b_o;
    logic       abort_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] ea, eb;
    logic [2:0] arm;
    logic       eab;

    always #2.5 clk = ~clk;

    flash_rw_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .alt_master_i(alt_master_i),
        .nmi_pin_i(nmi_pin_i), .nmi_evt_i(nmi_evt_i), .wdt_evt_i(wdt_evt_i),
        .wait_en_i(wait_en_i), .clk_slow_i(clk_slow_i),
        .ctrl_a_o(ctrl_a_o), .ctrl_b_o(ctrl_b_o), .abort_o(abort_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        return (a == 2'd0) ? ea : (a == 2'd1) ? eb : 8'h00;
    endfunction

    // Requirement model for one clock edge
    task automatic model(input logic we, input logic [1:0] a, input logic [7:0] d,
                         input logic alt, input logic ev);
        logic nab;
        nab = ev && ea[0];
        if (ev) begin
            ea = RA; eb = RB; arm = '0;
        end else begin
            for (int j = 0; j < 3; j++) begin
                logic [1:0] r;
                int p;
                logic b, own;
                r   = (j == 2) ? 2'd1 : 2'd0;
                p   = (j == 1) ? 1 : 0;
                b   = (r == 2'd0) ? ea[p] : eb[p];
                own = we && (a == r);
                if (own && !alt) begin
                    if (!d[p]) begin b = 1'b0; arm[j] = 1'b1; end
                    else begin
                        if (arm[j] && nmi_pin_i && (j != 0 || (wait_en_i && clk_slow_i))) b = 1'b1;
                        arm[j] = 1'b0;
                    end
                end else if (own && alt) begin
                    if (!d[p]) b = 1'b0;
                    arm[j] = 1'b0;
                end else if (we || alt) begin
                    arm[j] = 1'b0;
                end
                if (r == 2'd0) ea[p] = b; else eb[p] = b;
            end
            if (we && a == 2'd0) ea = (ea & PA) | (d & ~PA);
            if (we && a == 2'd1) eb = (eb & PB) | (d & ~PB);
        end
        eab = nab;
    endtask

    task automatic cyc(input logic we, input logic [1:0] a, input logic [7:0] d,
                       input logic alt, input logic ne, input logic wv, input string req);
        we_i = we; addr_i = a; wdata_i = d; alt_master_i = alt;
        nmi_evt_i = ne; wdt_evt_i = wv;
        @(posedge clk);
        model(we, a, d, alt, ne || wv);
        @(negedge clk);
        we_i = 1'b0; alt_master_i = 1'b0; nmi_evt_i = 1'b0; wdt_evt_i = 1'b0;
        chk(req, ctrl_a_o, ea);
        chk(req, ctrl_b_o, eb);
        chk(req, {7'd0, abort_o}, {7'd0, eab});
        chk(req, rdata_o, exp_rd(a));
    endtask

    task automatic do_reset();
        rst_ni = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_ni = 1'b1;
        ea = RA; eb = RB; arm = '0; eab = 1'b0;
        chk("R1 reset A", ctrl_a_o, RA);
        chk("R1 reset B", ctrl_b_o, RB);
        chk("R1 reset abort", {7'd0, abort_o}, 8'd0);
    endtask

    // Unlock guarded bit j (0: A0, 1: A1, 2: B0) with a clean sequence
    task automatic unlock(input int j, input string req);
        logic [1:0] r;
        logic [7:0] m;
        r = (j == 2) ? 2'd1 : 2'd0;
        m = (j == 1) ? 8'h02 : 8'h01;
        cyc(1'b1, r, exp_rd(r) & ~m, 1'b0, 1'b0, 1'b0, req);
        cyc(1'b1, r, exp_rd(r) | m, 1'b0, 1'b0, 1'b0, req);
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R2: plain bits, full data sweep on both registers
        for (int v = 0; v < 256; v++) begin
            cyc(1'b1, 2'd0, 8'(v), 1'b0, 1'b0, 1'b0, "R2 reg A");
            cyc(1'b1, 2'd1, 8'(v), 1'b0, 1'b0, 1'b0, "R2 reg B");
        end
        // R2/R10: unmapped addresses
        for (int a = 2; a < 4; a++) begin
            cyc(1'b1, 2'(a), 8'hFF, 1'b0, 1'b0, 1'b0, "R2 unmapped write");
            cyc(1'b0, 2'(a), 8'h00, 1'b0, 1'b0, 1'b0, "R10 unmapped read");
        end

        // R4-R7, R10: every guarded bit x pin/speed inputs x gap kind
        for (int j = 0; j < 3; j++) begin
            for (int c = 0; c < 8; c++) begin
                for (int g = 0; g < 5; g++) begin
                    logic [1:0] r, o;
                    logic [7:0] m;
                    string req;
                    r = (j == 2) ? 2'd1 : 2'd0;
                    o = (j == 2) ? 2'd0 : 2'd1;
                    m = (j == 1) ? 8'h02 : 8'h01;
                    nmi_pin_i  = c[0];
                    wait_en_i  = c[1];
                    clk_slow_i = c[2];
                    if (g == 3 || g == 4)  req = "R5 tagged gap";
                    else if (g == 1)       req = "R10 read gap";
                    else if (g == 2)       req = "R4 foreign write gap";
                    else if (!c[0])        req = "R6 pin low";
                    else if (j == 0)       req = "R7 speed gate";
                    else                   req = "R4 clean pair";
                    cyc(1'b1, r, exp_rd(r) & ~m, 1'b0, 1'b0, 1'b0, req);
                    case (g)
                        1: cyc(1'b0, r, 8'h00, 1'b0, 1'b0, 1'b0, req);
                        2: cyc(1'b1, o, exp_rd(o), 1'b0, 1'b0, 1'b0, req);
                        3: cyc(1'b0, r, 8'h00, 1'b1, 1'b0, 1'b0, req);
                        4: cyc(1'b1, r, exp_rd(r) | m, 1'b1, 1'b0, 1'b0, req);
                        default: ;
                    endcase
                    cyc(1'b1, r, exp_rd(r) | m, 1'b0, 1'b0, 1'b0, req);
                    cyc(1'b1, r, exp_rd(r) | m, 1'b0, 1'b0, 1'b0, "R4 repeat one");
                    cyc(1'b1, r, exp_rd(r) & ~m, 1'b1, 1'b0, 1'b0, "R3 clear");
                end
            end
        end
        nmi_pin_i = 1'b1; wait_en_i = 1'b1; clk_slow_i = 1'b1;

        // R8/R9: events with everything set
        for (int e = 0; e < 4; e++) begin
            unlock(0, "R4 unlock mode");
            unlock(1, "R4 unlock A1");
            unlock(2, "R4 unlock B0");
            cyc(1'b1, 2'd0, 8'h5F, 1'b0, 1'b0, 1'b0, "R2 fill A");
            cyc(1'b1, 2'd1, 8'hCB, 1'b0, 1'b0, 1'b0, "R2 fill B");
            cyc(e == 3, 2'd1, 8'hFF, 1'b0, e != 1, e == 1 || e == 2, "R8 event");
            cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, "R9 abort drops");
        end
        // R9: event with rewrite mode off gives no abort
        unlock(1, "R4 unlock A1");
        cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, "R9 no abort when idle");
        // R8: event drops a half-done sequence
        cyc(1'b1, 2'd1, 8'h00, 1'b0, 1'b0, 1'b0, "R8 arm");
        cyc(1'b0, 2'd1, 8'h00, 1'b0, 1'b0, 1'b1, "R8 event");
        cyc(1'b1, 2'd1, 8'h01, 1'b0, 1'b0, 1'b0, "R8 disarmed");

        // R1: reset after bits set, then sequence state gone
        unlock(0, "R4 unlock mode");
        cyc(1'b1, 2'd1, 8'h00, 1'b0, 1'b0, 1'b0, "R1 arm B0");
        do_reset();
        cyc(1'b1, 2'd1, 8'h01, 1'b0, 1'b0, 1'b0, "R1 disarmed by reset");

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule